// File: doc/BRIEF.md
# Rotating Tiled-View Address Generator

This block converts a pixel coordinate inside a tiled two-dimensional buffer into an address in a view space. The address encodes both the pixel format and one of eight rotated or mirrored views. A display or DMA engine presents a format code, a 3-bit view code and an X/Y coordinate with a request strobe. One clock later the block returns the composed address, a flag that says whether the coordinate fit the format's coordinate range, and the line stride to use when walking rows in that view.

The translation has four steps, which the block applies in order. It checks the coordinate against the per-format coordinate widths. It mirrors X and/or Y by inverting them across their full range. It concatenates the two coordinates with either Y or X in the upper field. It shifts the result left by the format's byte-alignment amount. The view and format codes are then placed above the offset. The block has no page table and no allocator; it performs address arithmetic only.

Top module: `tview_addr_gen`

## Requirements
- R1: When the coordinate is in range, address bits [28:27] carry the format code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page mode.
- R2: When the coordinate is in range, address bits [31:29] carry the view code unchanged. Bit 0 of that code requests Y mirroring, bit 1 requests X mirroring and bit 2 requests the X/Y swap.
- R3: The usable X width is 14 minus the format's X shift, and the usable Y width is 13 minus its Y shift. The shifts (X,Y) are (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit and (6,6) for page mode. A coordinate above its all-ones limit drives o_inrange low and the whole address to zero.
- R4: With view bit 0 set, Y is replaced by Y XOR its all-ones limit before the address is composed.
- R5: With view bit 1 set, X is replaced by X XOR its all-ones limit before the address is composed.
- R6: With view bit 2 clear, the offset is Y shifted left by the X width plus X. With view bit 2 set, it is X shifted left by the Y width plus Y.
- R7: The offset is shifted left by the sum of the format's X and Y shifts, and it fills address bits [26:0].
- R8: o_stride is 1 shifted left by (13 + X shift) when view bit 2 is set, and by (14 + Y shift) otherwise. It is always a single set bit.
- R9: All outputs update on the clock edge that samples i_req high, and o_valid is high for exactly those cycles. Without a request, o_addr, o_inrange and o_stride keep their previous values.
- R10: A synchronous reset clears o_valid, o_inrange, o_addr and o_stride to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_req | input | 1 | Request strobe; the inputs below are sampled when high |
| i_fmt | input | 2 | Pixel format code |
| i_view | input | 3 | View code: bit0 Y mirror, bit1 X mirror, bit2 X/Y swap |
| i_x | input | CW (16) | Pixel X coordinate |
| i_y | input | CW (16) | Pixel Y coordinate |
| o_valid | output | 1 | High one cycle after each request |
| o_inrange | output | 1 | Coordinate fit the format's limits |
| o_addr | output | XBITS+YBITS+5 (32) | Composed view-space address |
| o_stride | output | 32 | Line stride for the selected format and view |

## Verification
All four results (o_valid, o_inrange, o_addr, o_stride) come from a single register stage. Each is therefore due on the first rising edge after the edge that samples i_req. The bench drives a request on a falling edge and holds it for one rising edge. It then drops the strobe and samples on the following falling edge, so every value it reads is from the edge that consumed that request. A separate directed step leaves the strobe low for several cycles with changing inputs and confirms that o_valid stays low and the held outputs do not move.

// File: rtl/tview_pkg.sv
package tview_pkg;

  // format codes (also the value placed in the address format field)
  typedef enum logic [1:0] {
    FMT_B8   = 2'd0,
    FMT_B16  = 2'd1,
    FMT_B32  = 2'd2,
    FMT_PAGE = 2'd3
  } tview_fmt_e;

  // view code bit positions
  localparam int VBIT_YMIR = 0;
  localparam int VBIT_XMIR = 1;
  localparam int VBIT_SWAP = 2;

  typedef struct packed {
    logic [3:0] xsh;
    logic [3:0] ysh;
  } tview_shift_t;

endpackage

// File: rtl/tview_geom.sv
module tview_geom
  import tview_pkg::*;
#(
  parameter int XBITS    = 14,
  parameter int YBITS    = 13,
  parameter int PAGE_XSH = 6,
  parameter int PAGE_YSH = 6
) (
  input  logic [1:0] fmt,
  output logic [3:0] xsh,
  output logic [3:0] ysh,
  output logic [4:0] xw,
  output logic [4:0] yw,
  output logic [4:0] align
);

  tview_shift_t sh;

  always_comb begin
    unique case (tview_fmt_e'(fmt))
      FMT_B8:   sh = '{xsh: 4'd0, ysh: 4'd0};
      FMT_B16:  sh = '{xsh: 4'd0, ysh: 4'd1};
      FMT_B32:  sh = '{xsh: 4'd1, ysh: 4'd1};
      default:  sh = '{xsh: 4'(PAGE_XSH), ysh: 4'(PAGE_YSH)};
    endcase
  end

  assign xsh   = sh.xsh;
  assign ysh   = sh.ysh;
  assign xw    = 5'(XBITS) - {1'b0, sh.xsh};
  assign yw    = 5'(YBITS) - {1'b0, sh.ysh};
  assign align = {1'b0, sh.xsh} + {1'b0, sh.ysh};

  // the three fields must always add up to the full offset width
  always_comb begin
    if (!$isunknown(fmt))
      assert (xw + yw + align == 5'(XBITS + YBITS))
        else $error("AST_GEOM_SPAN: widths do not fill offset"); // R7
  end

endmodule

// File: rtl/tview_xform.sv
module tview_xform
  import tview_pkg::*;
#(
  parameter int XBITS = 14,
  parameter int YBITS = 13,
  parameter int CW    = 16,
  localparam int OFFW = XBITS + YBITS
) (
  input  logic [CW-1:0]   x,
  input  logic [CW-1:0]   y,
  input  logic [2:0]      view,
  input  logic [4:0]      xw,
  input  logic [4:0]      yw,
  input  logic [4:0]      align,
  output logic            inrange,
  output logic [OFFW-1:0] offset
);

  logic [OFFW-1:0] xmask, ymask;
  logic [OFFW-1:0] xe, ye;
  logic [OFFW-1:0] xm, ym;
  logic [OFFW-1:0] packed_xy;
  logic            x_hi_bits, y_hi_bits;

  assign xmask = (OFFW'(1) << xw) - OFFW'(1);
  assign ymask = (OFFW'(1) << yw) - OFFW'(1);

  generate
    if (CW > OFFW) begin : g_wide
      assign xe = x[OFFW-1:0];
      assign ye = y[OFFW-1:0];
      assign x_hi_bits = |x[CW-1:OFFW];
      assign y_hi_bits = |y[CW-1:OFFW];
    end else begin : g_narrow
      assign xe = OFFW'(x);
      assign ye = OFFW'(y);
      assign x_hi_bits = 1'b0;
      assign y_hi_bits = 1'b0;
    end
  endgenerate

  assign inrange = !x_hi_bits && !y_hi_bits && (xe <= xmask) && (ye <= ymask);

  // mirroring
  assign xm = view[VBIT_XMIR] ? (xe ^ xmask) : xe;
  assign ym = view[VBIT_YMIR] ? (ye ^ ymask) : ye;

  // field order
  assign packed_xy = view[VBIT_SWAP] ? ((xm << yw) + ym) : ((ym << xw) + xm);

  assign offset = packed_xy << align;

endmodule

// File: rtl/tview_stride.sv
module tview_stride
  import tview_pkg::*;
#(
  parameter int XBITS = 14,
  parameter int YBITS = 13,
  parameter int SW    = 32
) (
  input  logic [3:0]    xsh,
  input  logic [3:0]    ysh,
  input  logic          swap,
  output logic [SW-1:0] stride
);

  logic [5:0] pos;

  assign pos    = swap ? (6'(YBITS) + {2'b0, xsh}) : (6'(XBITS) + {2'b0, ysh});
  assign stride = SW'(1) << pos;

endmodule

// File: rtl/tview_addr_gen.sv
module tview_addr_gen
  import tview_pkg::*;
#(
  parameter int XBITS    = 14,
  parameter int YBITS    = 13,
  parameter int PAGE_XSH = 6,
  parameter int PAGE_YSH = 6,
  parameter int CW       = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   i_req,
  input  logic [1:0]             i_fmt,
  input  logic [2:0]             i_view,
  input  logic [CW-1:0]          i_x,
  input  logic [CW-1:0]          i_y,
  output logic                   o_valid,
  output logic                   o_inrange,
  output logic [XBITS+YBITS+4:0] o_addr,
  output logic [31:0]            o_stride
);

  localparam int OFFW = XBITS + YBITS;
  localparam int AW   = OFFW + 5;
  localparam int FLO  = OFFW;
  localparam int FHI  = OFFW + 1;
  localparam int VLO  = OFFW + 2;
  localparam int VHI  = OFFW + 4;

  logic [3:0]      xsh, ysh;
  logic [4:0]      xw, yw, align;
  logic            inr;
  logic [OFFW-1:0] offset;
  logic [31:0]     stride;

  tview_geom #(
    .XBITS(XBITS), .YBITS(YBITS), .PAGE_XSH(PAGE_XSH), .PAGE_YSH(PAGE_YSH)
  ) u_geom (
    .fmt(i_fmt), .xsh(xsh), .ysh(ysh), .xw(xw), .yw(yw), .align(align)
  );

  tview_xform #(
    .XBITS(XBITS), .YBITS(YBITS), .CW(CW)
  ) u_xform (
    .x(i_x), .y(i_y), .view(i_view), .xw(xw), .yw(yw), .align(align),
    .inrange(inr), .offset(offset)
  );

  tview_stride #(
    .XBITS(XBITS), .YBITS(YBITS), .SW(32)
  ) u_stride (
    .xsh(xsh), .ysh(ysh), .swap(i_view[VBIT_SWAP]), .stride(stride)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid   <= 1'b0;
      o_inrange <= 1'b0;
      o_addr    <= '0;
      o_stride  <= '0;
    end else begin
      o_valid <= i_req;
      if (i_req) begin
        o_inrange <= inr;
        o_addr    <= inr ? {i_view, i_fmt, offset} : AW'(0);
        o_stride  <= stride;
      end
    end
  end

  AST_FMT_FIELD: assert property (@(posedge clk) disable iff (rst)
    (!rst && i_req) |=> (!o_inrange || o_addr[FHI:FLO] == $past(i_fmt))); // R1

  AST_VIEW_FIELD: assert property (@(posedge clk) disable iff (rst)
    (!rst && i_req) |=> (!o_inrange || o_addr[VHI:VLO] == $past(i_view))); // R2

  AST_ZERO_WHEN_BAD: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_inrange) |-> (o_addr == '0)); // R3

  AST_STRIDE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> ($countones(o_stride) == 1)); // R8

  AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (!rst && !i_req) |=> !o_valid); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!rst && !i_req) |=> ($stable(o_addr) && $stable(o_stride) && $stable(o_inrange))); // R9

endmodule

// File: tb/tview_addr_gen_test.sv
`timescale 1ns/1ps
module tview_addr_gen_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        req;
  logic [1:0]  fmt;
  logic [2:0]  view;
  logic [15:0] x, y;
  logic        o_valid, o_inrange;
  logic [31:0] o_addr, o_stride;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tview_addr_gen uut (
    .clk(clk), .rst(rst), .i_req(req), .i_fmt(fmt), .i_view(view),
    .i_x(x), .i_y(y), .o_valid(o_valid), .o_inrange(o_inrange),
    .o_addr(o_addr), .o_stride(o_stride)
  );

  // {fmt, view, x, y, addr, inrange, stride}
  localparam int NV = 12;
  localparam logic [101:0] VEC [NV] = '{
    {2'd0, 3'd0, 16'h0005, 16'h0003, 32'h0000C005, 1'b1, 32'h00004000}, // R1 R6 plain
    {2'd0, 3'd2, 16'h0005, 16'h0003, 32'h4000FFFA, 1'b1, 32'h00004000}, // R5 X mirror
    {2'd0, 3'd1, 16'h0005, 16'h0003, 32'h27FF0005, 1'b1, 32'h00004000}, // R4 Y mirror
    {2'd0, 3'd4, 16'h0005, 16'h0003, 32'h8000A003, 1'b1, 32'h00002000}, // R6 swap
    {2'd1, 3'd0, 16'h0010, 16'h0002, 32'h08010020, 1'b1, 32'h00008000}, // R7 16-bit
    {2'd2, 3'd3, 16'h0001, 16'h0001, 32'h77FF7FF8, 1'b1, 32'h00008000}, // R4 R5 32-bit
    {2'd3, 3'd6, 16'h0012, 16'h0005, 32'hDF685000, 1'b1, 32'h00080000}, // R2 page swap+Xmir
    {2'd3, 3'd0, 16'h00FF, 16'h007F, 32'h1FFFF000, 1'b1, 32'h00100000}, // R3 page limits
    {2'd3, 3'd0, 16'h0100, 16'h0000, 32'h00000000, 1'b0, 32'h00100000}, // R3 page X over
    {2'd0, 3'd0, 16'h3FFF, 16'h2000, 32'h00000000, 1'b0, 32'h00004000}, // R3 8-bit Y over
    {2'd2, 3'd5, 16'h1FFF, 16'h0000, 32'hB7FFFFFC, 1'b1, 32'h00004000}, // R8 swap stride
    {2'd1, 3'd7, 16'h0000, 16'h0000, 32'hEFFFFFFE, 1'b1, 32'h00002000}  // R2 R7 all bits
  };

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] f, input logic [2:0] v,
                       input logic [15:0] xi, input logic [15:0] yi);
    @(negedge clk);
    req = 1'b1; fmt = f; view = v; x = xi; y = yi;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req = 1'b0; fmt = '0; view = '0; x = '0; y = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check32("R10 valid", 32'(o_valid), 32'd0);
    check32("R10 inrange", 32'(o_inrange), 32'd0);
    check32("R10 addr", o_addr, 32'd0);
    check32("R10 stride", o_stride, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][101:100], VEC[i][99:97], VEC[i][96:81], VEC[i][80:65]);
      check32($sformatf("R9 valid v%0d", i), 32'(o_valid), 32'd1);
      check32($sformatf("R1 R2 R4 R5 R6 R7 addr v%0d", i), o_addr, VEC[i][64:33]);
      check32($sformatf("R3 inrange v%0d", i), 32'(o_inrange), 32'(VEC[i][32]));
      check32($sformatf("R8 stride v%0d", i), o_stride, VEC[i][31:0]);
    end

    // R9: valid lasts one cycle, outputs hold while idle with inputs moving
    apply(2'd0, 3'd0, 16'h0005, 16'h0003);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      fmt = 2'd3; view = 3'd7; x = 16'h0011; y = 16'h0022;
      check32("R9 valid low idle", 32'(o_valid), 32'd0);
      check32("R9 addr held", o_addr, 32'h0000C005);
      check32("R9 stride held", o_stride, 32'h00004000);
    end

    // R9 latency: output not yet updated before the sampling edge
    @(negedge clk);
    req = 1'b1; fmt = 2'd0; view = 3'd4; x = 16'h0005; y = 16'h0003;
    #1;
    check32("R9 no early update", o_addr, 32'h0000C005);
    @(negedge clk);
    req = 1'b0;
    check32("R9 one-cycle result", o_addr, 32'h8000A003);

    // R10 reset after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check32("R10 addr after reset", o_addr, 32'd0);
    check32("R10 stride after reset", o_stride, 32'd0);
    check32("R10 inrange after reset", 32'(o_inrange), 32'd0);
    rst = 1'b0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule